// File: doc/BRIEF.md
# Burst Symbol Timing and Frequency Offset Estimator

This block finds the best sampling instant within a symbol, and the carrier frequency offset, for one received burst of π/4-shifted DQPSK. Its input is a stream of absolute phase samples taken ten times per symbol. A burst-start strobe marks the first sample of the burst. The block treats each of the ten sample positions in a symbol as a candidate sampling offset.

For each candidate, the phase step between samples one symbol apart is multiplied by four. This removes the data modulation: every ideal symbol step then lands on an angle of π. The multiplied step is turned into a unit vector and added into a per-candidate vector sum over a fixed window of symbols. When the window closes, the candidate with the largest squared magnitude is reported as the timing estimate. The same winning sum gives the frequency offset per symbol, taken from its angle.

The block is placed after phase extraction. Its estimate seeds the carrier recovery and downsampling stages that follow it.

Top module: `eye_timing_est`

## Requirements
- R1: While reset is held low and after it is released, `est_vld_o` is 0, and `best_ofs_o`, `qi_o` and `freq_o` are all zero until the first estimate.
- R2: Phases are 8-bit two's-complement, where 256 codes span one full turn. For each offset j, the step is the phase at sample j of symbol n minus the phase at sample j of symbol n-1, wrapped modulo 256. This step is multiplied by four, also modulo 256.
- R3: Each fourfold step at code a contributes round(127·cos(2πa/256)) to the X sum of its offset and round(127·sin(2πa/256)) to the Y sum. Only steps ending in symbols 11 through 48 are counted; the sample that carries the burst-start strobe is sample 0 of symbol 0. Samples in other symbols have no effect on any output.
- R4: `qi_o` equals X²+Y² of the winning offset, and `best_ofs_o` (0 to 9) is the offset whose X²+Y² is largest.
- R5: When several offsets share the largest X²+Y², the lowest offset index wins.
- R6: `freq_o` is (angle(X,Y) − π)/4 for the winning sum. It is a signed 8-bit value in units of 2π/256 per symbol, with a range of about ±π/4, and is accurate to within one code.
- R7: `est_vld_o` pulses high for exactly one cycle, once per burst, after the window closes. The three result outputs change only in that cycle and hold their values otherwise.
- R8: A burst-start strobe restarts accumulation at once, abandoning any burst in progress, including one already past its window. The abandoned burst produces no estimate.
- R9: Cycles with `phase_vld_i` low do not advance the sample count, and the phase they carry is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| burst_start_i | input | 1 | Marks the current valid sample as sample 0 of a burst |
| phase_vld_i | input | 1 | Phase sample valid |
| phase_i | input | 8 | Absolute phase, two's complement, 256 codes per turn |
| est_vld_o | output | 1 | One-cycle strobe: a new estimate is on the outputs |
| best_ofs_o | output | 4 | Chosen sampling offset, 0 to 9 |
| qi_o | output | 28 | Squared magnitude of the winning sum |
| freq_o | output | 8 | Frequency offset per symbol, signed, 2π/256 units |

## Verification
Several corner cases are targeted directly:
- **Ties.** Two offsets carry identical phase steps. A comparison using ≥ instead of > would report the higher offset.
- **Data outside the window.** Bursts fill the symbols outside the window with random phase. A window boundary off by one symbol would change `qi_o`, and could move the chosen offset.
- **Large frequency steps.** Steps of up to 28 codes per symbol exercise the wrap of the fourfold multiply and the quadrant correction in the angle unit. A missing half-turn pre-rotation would flip the sign or size of `freq_o`.
- **Sample gaps and restarts.** Gaps in `phase_vld_i`, and restarts both mid-window and just after the window closes, catch counters that advance on invalid cycles. They also catch a late estimate from an abandoned burst leaking out as a second strobe.

// File: rtl/eye_pkg.sv
package eye_pkg;

  localparam real PI_R = 3.14159265358979323846;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_ACC  = 2'd1,
    ST_SCAN = 2'd2,
    ST_CORD = 2'd3
  } est_state_e;

  function automatic int round_r(real r);
    return (r >= 0.0) ? $rtoi(r + 0.5) : -$rtoi(0.5 - r);
  endfunction

endpackage

// File: rtl/eye_trig_lut.sv
module eye_trig_lut
  import eye_pkg::*;
#(
  parameter int PH_W   = 8,
  parameter int TRIG_W = 8
) (
  input  logic [PH_W-1:0]          ang_i,
  output logic signed [TRIG_W-1:0] cos_o,
  output logic signed [TRIG_W-1:0] sin_o
);
  localparam int  N   = 2 ** PH_W;
  localparam real AMP = real'(2 ** (TRIG_W - 1) - 1);

  logic signed [TRIG_W-1:0] cos_tab [N];
  logic signed [TRIG_W-1:0] sin_tab [N];

  for (genvar i = 0; i < N; i++) begin : g_tab
    localparam real ANG = 2.0 * PI_R * real'(i) / real'(N);
    assign cos_tab[i] = TRIG_W'(round_r(AMP * $cos(ANG)));
    assign sin_tab[i] = TRIG_W'(round_r(AMP * $sin(ANG)));
  end

  assign cos_o = cos_tab[ang_i];
  assign sin_o = sin_tab[ang_i];

endmodule

// File: rtl/eye_cordic.sv
// Iterative vectoring: returns atan2(y, x) as an ANG_W-bit fraction of a turn.
module eye_cordic
  import eye_pkg::*;
#(
  parameter int IN_W  = 15,
  parameter int ITER  = 12,
  parameter int ANG_W = 8,
  parameter int Z_W   = 16
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   start_i,
  input  logic signed [IN_W-1:0] x_i,
  input  logic signed [IN_W-1:0] y_i,
  output logic                   done_o,
  output logic [ANG_W-1:0]       ang_o
);
  localparam int XW   = IN_W + 2;
  localparam int IT_W = $clog2(ITER + 1);

  logic [Z_W-1:0] atan_tab [ITER];
  for (genvar i = 0; i < ITER; i++) begin : g_atan
    localparam int AT = round_r($atan(2.0 ** (-real'(i))) * real'(2 ** Z_W) / (2.0 * PI_R));
    assign atan_tab[i] = Z_W'(AT);
  end

  logic signed [XW-1:0] x_q, y_q, xe, ye;
  logic [Z_W-1:0]       z_q, z_rnd;
  logic [IT_W-1:0]      it_q;
  logic                 busy_q;

  assign xe = XW'(x_i);
  assign ye = XW'(y_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      x_q <= '0; y_q <= '0; z_q <= '0; it_q <= '0;
      busy_q <= 1'b0; done_o <= 1'b0;
    end else begin
      done_o <= 1'b0;
      if (start_i) begin
        // fold left half-plane onto the right so the iterations converge
        x_q    <= (x_i < 0) ? -xe : xe;
        y_q    <= (x_i < 0) ? -ye : ye;
        z_q    <= (x_i < 0) ? Z_W'(1) << (Z_W - 1) : '0;
        it_q   <= '0;
        busy_q <= 1'b1;
      end else if (busy_q) begin
        if (y_q > 0) begin
          x_q <= x_q + (y_q >>> it_q);
          y_q <= y_q - (x_q >>> it_q);
          z_q <= z_q + atan_tab[it_q];
        end else begin
          x_q <= x_q - (y_q >>> it_q);
          y_q <= y_q + (x_q >>> it_q);
          z_q <= z_q - atan_tab[it_q];
        end
        it_q <= it_q + 1'b1;
        if (it_q == IT_W'(ITER - 1)) begin
          busy_q <= 1'b0;
          done_o <= 1'b1;
        end
      end
    end
  end

  assign z_rnd = z_q + (Z_W'(1) << (Z_W - ANG_W - 1));
  assign ang_o = z_rnd[Z_W-1 -: ANG_W];

endmodule

// File: rtl/eye_timing_est.sv
module eye_timing_est
  import eye_pkg::*;
#(
  parameter  int SPS       = 10,
  parameter  int PH_W      = 8,
  parameter  int TRIG_W    = 8,
  parameter  int WIN_START = 11,
  parameter  int WIN_LEN   = 38,
  parameter  int CORD_ITER = 12,
  localparam int OFS_W     = $clog2(SPS),
  localparam int ACC_W     = TRIG_W + $clog2(WIN_LEN + 1),
  localparam int QI_W      = 2 * ACC_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             burst_start_i,
  input  logic             phase_vld_i,
  input  logic [PH_W-1:0]  phase_i,
  output logic             est_vld_o,
  output logic [OFS_W-1:0] best_ofs_o,
  output logic [QI_W-1:0]  qi_o,
  output logic [PH_W-1:0]  freq_o
);
  localparam int WIN_END = WIN_START + WIN_LEN - 1;
  localparam int SYM_W   = $clog2(WIN_END + 2);
  localparam int CX_W    = ACC_W + 1;

  est_state_e st_q;
  logic [PH_W-1:0]  dly_q [SPS];
  logic [OFS_W-1:0] ofs_q, scan_idx_q, best_idx_q;
  logic [SYM_W-1:0] sym_q;
  logic signed [ACC_W-1:0] acc_x_q [SPS];
  logic signed [ACC_W-1:0] acc_y_q [SPS];
  logic signed [ACC_W-1:0] best_x_q, best_y_q, sel_x, sel_y;
  logic [QI_W-1:0]  best_qi_q, scan_qi;
  logic             cord_go_q, cord_done, restart, in_win, take, win_last;
  logic [PH_W-1:0]  diff, quad_ang, cord_ang;
  logic signed [TRIG_W-1:0] lut_c, lut_s;
  logic signed [CX_W-1:0]   cord_x, cord_y;

  assign restart  = phase_vld_i && burst_start_i;
  assign diff     = phase_i - dly_q[SPS-1];
  assign quad_ang = {diff[PH_W-3:0], 2'b00};
  assign in_win   = (st_q == ST_ACC) && (sym_q >= SYM_W'(WIN_START)) && (sym_q <= SYM_W'(WIN_END));
  assign take     = phase_vld_i && !burst_start_i && in_win;
  assign win_last = take && (sym_q == SYM_W'(WIN_END)) && (ofs_q == OFS_W'(SPS - 1));

  eye_trig_lut #(.PH_W(PH_W), .TRIG_W(TRIG_W)) u_lut (
    .ang_i (quad_ang),
    .cos_o (lut_c),
    .sin_o (lut_s)
  );

  // sample history: dly_q[SPS-1] is one symbol back
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < SPS; i++) dly_q[i] <= '0;
    end else if (phase_vld_i) begin
      dly_q[0] <= phase_i;
      for (int i = 1; i < SPS; i++) dly_q[i] <= dly_q[i-1];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ofs_q <= '0;
      sym_q <= '0;
    end else if (phase_vld_i) begin
      if (burst_start_i) begin
        ofs_q <= OFS_W'(1);
        sym_q <= '0;
      end else if (ofs_q == OFS_W'(SPS - 1)) begin
        ofs_q <= '0;
        if (sym_q <= SYM_W'(WIN_END)) sym_q <= sym_q + 1'b1;
      end else begin
        ofs_q <= ofs_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < SPS; i++) begin
        acc_x_q[i] <= '0;
        acc_y_q[i] <= '0;
      end
    end else if (restart) begin
      for (int i = 0; i < SPS; i++) begin
        acc_x_q[i] <= '0;
        acc_y_q[i] <= '0;
      end
    end else if (take) begin
      acc_x_q[ofs_q] <= acc_x_q[ofs_q] + ACC_W'(lut_c);
      acc_y_q[ofs_q] <= acc_y_q[ofs_q] + ACC_W'(lut_s);
    end
  end

  assign sel_x   = acc_x_q[scan_idx_q];
  assign sel_y   = acc_y_q[scan_idx_q];
  assign scan_qi = QI_W'(sel_x * sel_x) + QI_W'(sel_y * sel_y);

  // angle(-S) = angle(S) - pi
  assign cord_x = -CX_W'(best_x_q);
  assign cord_y = -CX_W'(best_y_q);

  eye_cordic #(.IN_W(CX_W), .ITER(CORD_ITER), .ANG_W(PH_W)) u_cordic (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (cord_go_q),
    .x_i     (cord_x),
    .y_i     (cord_y),
    .done_o  (cord_done),
    .ang_o   (cord_ang)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q       <= ST_IDLE;
      scan_idx_q <= '0;
      best_idx_q <= '0;
      best_qi_q  <= '0;
      best_x_q   <= '0;
      best_y_q   <= '0;
      cord_go_q  <= 1'b0;
      est_vld_o  <= 1'b0;
      best_ofs_o <= '0;
      qi_o       <= '0;
      freq_o     <= '0;
    end else begin
      est_vld_o <= 1'b0;
      cord_go_q <= 1'b0;
      if (restart) begin
        st_q <= ST_ACC;
      end else begin
        unique case (st_q)
          ST_IDLE: ;
          ST_ACC: if (win_last) begin
            st_q       <= ST_SCAN;
            scan_idx_q <= '0;
          end
          ST_SCAN: begin
            // strict compare keeps the lowest index on ties
            if (scan_idx_q == '0 || scan_qi > best_qi_q) begin
              best_qi_q  <= scan_qi;
              best_idx_q <= scan_idx_q;
              best_x_q   <= sel_x;
              best_y_q   <= sel_y;
            end
            if (scan_idx_q == OFS_W'(SPS - 1)) begin
              st_q      <= ST_CORD;
              cord_go_q <= 1'b1;
            end else begin
              scan_idx_q <= scan_idx_q + 1'b1;
            end
          end
          ST_CORD: if (cord_done) begin
            st_q       <= ST_IDLE;
            est_vld_o  <= 1'b1;
            best_ofs_o <= best_idx_q;
            qi_o       <= best_qi_q;
            freq_o     <= PH_W'($signed(cord_ang) >>> 2);
          end
          default: st_q <= ST_IDLE;
        endcase
      end
    end
  end

endmodule

// File: rtl/eye_timing_est_chk.sv
module eye_timing_est_chk #(
  parameter int SPS       = 10,
  parameter int WIN_START = 11,
  parameter int WIN_LEN   = 38,
  parameter int OFS_W     = 4,
  parameter int QI_W      = 28,
  parameter int PH_W      = 8
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             burst_start_i,
  input logic             phase_vld_i,
  input logic             est_vld_o,
  input logic [OFS_W-1:0] best_ofs_o,
  input logic [QI_W-1:0]  qi_o,
  input logic [PH_W-1:0]  freq_o
);
  localparam int MIN_SAMP = (WIN_START + WIN_LEN) * SPS;
  localparam int CNT_W    = $clog2(MIN_SAMP + 2);

  logic             armed_q;
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      armed_q <= 1'b0;
      cnt_q   <= '0;
    end else begin
      if (phase_vld_i && burst_start_i) begin
        armed_q <= 1'b1;
        cnt_q   <= CNT_W'(1);
      end else begin
        if (est_vld_o) armed_q <= 1'b0;
        if (phase_vld_i && cnt_q <= CNT_W'(MIN_SAMP)) cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  AST_VLD_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    est_vld_o |=> !est_vld_o); // R7
  AST_OUT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !est_vld_o |-> $stable(best_ofs_o) && $stable(qi_o) && $stable(freq_o)); // R7
  AST_ONE_PER_BURST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    est_vld_o |-> armed_q); // R7
  AST_AFTER_WINDOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    est_vld_o |-> cnt_q >= CNT_W'(MIN_SAMP)); // R3
  AST_OFS_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    est_vld_o |-> best_ofs_o < OFS_W'(SPS)); // R4
  AST_RESTART_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    phase_vld_i && burst_start_i |=> !est_vld_o); // R8

endmodule

bind eye_timing_est eye_timing_est_chk #(
  .SPS(SPS), .WIN_START(WIN_START), .WIN_LEN(WIN_LEN),
  .OFS_W(OFS_W), .QI_W(QI_W), .PH_W(PH_W)
) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .burst_start_i (burst_start_i),
  .phase_vld_i   (phase_vld_i),
  .est_vld_o     (est_vld_o),
  .best_ofs_o    (best_ofs_o),
  .qi_o          (qi_o),
  .freq_o        (freq_o)
);

// File: tb/eye_timing_est_tb.sv
module eye_timing_est_tb;
  localparam int SPS = 10, NSYM = 60, NS = SPS * NSYM, WS = 11, WE = 48;
  localparam real PI_T = 3.14159265358979323846;

  logic clk = 1'b0, rst_n = 1'b0;
  logic bs = 1'b0, pv = 1'b0;
  logic [7:0] ph = '0;
  logic ev;
  logic [3:0] bo;
  logic [27:0] qi;
  logic [7:0] fo;

  always #10 clk = ~clk;

  eye_timing_est u_dut (
    .clk_i(clk), .rst_ni(rst_n), .burst_start_i(bs), .phase_vld_i(pv), .phase_i(ph),
    .est_vld_o(ev), .best_ofs_o(bo), .qi_o(qi), .freq_o(fo)
  );

  typedef struct packed {
    logic [3:0]        k;
    logic [3:0]        k2;
    logic signed [7:0] step;
    logic              gaps;
    logic              garb;
    logic [3:0]        exp_ofs;
    logic signed [7:0] exp_frq;
  } vec_t;

  localparam vec_t VECS [8] = '{
    '{4'd0, 4'hF,  8'sd0,  1'b0, 1'b0, 4'd0,  8'sd0},
    '{4'd4, 4'hF,  8'sd5,  1'b0, 1'b0, 4'd4,  8'sd5},
    '{4'd9, 4'hF, -8'sd9,  1'b0, 1'b0, 4'd9, -8'sd9},
    '{4'd6, 4'hF,  8'sd15, 1'b1, 1'b0, 4'd6,  8'sd15},
    '{4'd2, 4'hF, -8'sd20, 1'b0, 1'b1, 4'd2, -8'sd20},
    '{4'd7, 4'd3,  8'sd3,  1'b0, 1'b0, 4'd3,  8'sd3},
    '{4'd1, 4'd8, -8'sd2,  1'b0, 1'b0, 4'd1, -8'sd2},
    '{4'd5, 4'hF,  8'sd28, 1'b1, 1'b1, 4'd5,  8'sd28}
  };

  int n_chk = 0, n_err = 0;
  int cap_cnt = 0, cap_ofs = 0, cap_frq = 0, cap_qi = 0;
  int ph_buf [NS];
  bit [31:0] rs = 32'h1357_2468;

  always @(negedge clk) begin
    if (rst_n && ev) begin
      cap_cnt++;
      cap_ofs = int'(bo);
      cap_frq = int'($signed(fo));
      cap_qi  = int'(qi);
    end
  end

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic int rnd_range(int m);
    rs = rs * 32'd1664525 + 32'd1013904223;
    if (m == 0) return 0;
    return int'(rs[31:16] % (2 * m + 1)) - m;
  endfunction

  function automatic int rnd_r(real r);
    return (r >= 0.0) ? $rtoi(r + 0.5) : -$rtoi(0.5 - r);
  endfunction

  function automatic int lut_c(int a);
    return rnd_r(127.0 * $cos(2.0 * PI_T * real'(a & 255) / 256.0));
  endfunction

  function automatic int lut_s(int a);
    return rnd_r(127.0 * $sin(2.0 * PI_T * real'(a & 255) / 256.0));
  endfunction

  task automatic gen_burst(input int k, input int k2, input int step, input bit garb);
    int theta, d, jit, q;
    theta = rnd_range(127);
    for (int n = 0; n < NSYM; n++) begin
      if (n > 0) begin
        q = rnd_range(2);
        theta += ((q <= 0) ? ((q == 0) ? 32 : 96) : ((q == 1) ? -32 : -96)) + step;
      end
      for (int j = 0; j < SPS; j++) begin
        d = (j > k) ? j - k : k - j;
        if (d > SPS / 2) d = SPS - d;
        jit = (j == k || j == k2) ? 0 : rnd_range(d * 6);
        if (garb && (n < WS - 1 || n > WE)) ph_buf[n*SPS+j] = rnd_range(127);
        else ph_buf[n*SPS+j] = theta + jit;
      end
    end
  endtask

  task automatic model(output int best, output int bq);
    int x, y, a, qv;
    best = 0; bq = -1;
    for (int j = 0; j < SPS; j++) begin
      x = 0; y = 0;
      for (int n = WS; n <= WE; n++) begin
        a = 4 * (ph_buf[n*SPS+j] - ph_buf[(n-1)*SPS+j]);
        x += lut_c(a);
        y += lut_s(a);
      end
      qv = x * x + y * y;
      if (qv > bq) begin bq = qv; best = j; end
    end
  endtask

  task automatic send(input int first, input int last, input bit gaps);
    for (int s = first; s <= last; s++) begin
      if (gaps && (s % 3 == 2)) begin
        @(negedge clk);
        pv = 1'b0; bs = 1'b1; ph = 8'(rnd_range(127));
      end
      @(negedge clk);
      pv = 1'b1; bs = (s == 0); ph = 8'(ph_buf[s]);
    end
    @(negedge clk);
    pv = 1'b0; bs = 1'b0;
  endtask

  task automatic summary;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog actual=timeout expected=done");
    summary();
    $finish;
  end

  initial begin
    int mb, mq, c0, df;
    repeat (3) @(negedge clk);
    // R1: outputs during reset
    chk(ev == 1'b0, "R1", "est_vld in reset", int'(ev), 0);
    chk(bo == '0 && fo == '0, "R1", "ofs/freq in reset", int'(bo), 0);
    chk(qi == '0, "R1", "qi in reset", int'(qi), 0);
    rst_n = 1'b1;
    repeat (20) @(negedge clk);
    chk(cap_cnt == 0, "R1", "strobe without burst", cap_cnt, 0);
    chk(qi == '0 && bo == '0, "R1", "idle outputs", int'(qi), 0);

    // table walk: R2 R3 R4 R5 R6 R7 R9
    for (int v = 0; v < 8; v++) begin
      gen_burst(int'(VECS[v].k), int'(VECS[v].k2), int'(VECS[v].step), VECS[v].garb);
      model(mb, mq);
      c0 = cap_cnt;
      send(0, NS - 1, VECS[v].gaps);
      repeat (60) @(negedge clk);
      chk(cap_cnt == c0 + 1, "R7", "one strobe per burst", cap_cnt - c0, 1);
      chk(cap_ofs == mb, "R4", "offset vs model", cap_ofs, mb);
      chk(cap_qi == mq, "R2", "qi vs model", cap_qi, mq);
      if (VECS[v].k2 != 4'hF)
        chk(cap_ofs == int'(VECS[v].exp_ofs), "R5", "tie to lowest", cap_ofs, int'(VECS[v].exp_ofs));
      else if (VECS[v].garb)
        chk(cap_ofs == int'(VECS[v].exp_ofs), "R3", "offset with junk outside window", cap_ofs, int'(VECS[v].exp_ofs));
      else if (VECS[v].gaps)
        chk(cap_ofs == int'(VECS[v].exp_ofs), "R9", "offset with valid gaps", cap_ofs, int'(VECS[v].exp_ofs));
      else
        chk(cap_ofs == int'(VECS[v].exp_ofs), "R4", "offset vs table", cap_ofs, int'(VECS[v].exp_ofs));
      df = cap_frq - int'(VECS[v].exp_frq);
      chk(df >= -1 && df <= 1, "R6", "freq", cap_frq, int'(VECS[v].exp_frq));
      chk(int'(bo) == cap_ofs && int'(qi) == cap_qi, "R7", "hold after strobe", int'(bo), cap_ofs);
    end

    // R8: restart mid-window
    gen_burst(2, 15, 4, 1'b0);
    send(0, 299, 1'b0);
    gen_burst(8, 15, -6, 1'b0);
    model(mb, mq);
    c0 = cap_cnt;
    send(0, NS - 1, 1'b0);
    repeat (60) @(negedge clk);
    chk(cap_cnt == c0 + 1, "R8", "strobes after mid restart", cap_cnt - c0, 1);
    chk(cap_ofs == 8 && cap_qi == mq, "R8", "result of new burst", cap_ofs, 8);

    // R8: restart right after the window closed
    gen_burst(3, 15, 7, 1'b0);
    c0 = cap_cnt;
    send(0, (WE + 1) * SPS, 1'b0);
    gen_burst(6, 15, -11, 1'b0);
    model(mb, mq);
    send(0, NS - 1, 1'b0);
    repeat (60) @(negedge clk);
    chk(cap_cnt == c0 + 1, "R8", "strobes after late restart", cap_cnt - c0, 1);
    chk(cap_ofs == 6 && cap_qi == mq, "R8", "late restart result", cap_ofs, 6);
    df = cap_frq + 11;
    chk(df >= -1 && df <= 1, "R6", "freq after restart", cap_frq, -11);

    summary();
    $finish;
  end

endmodule